// File: doc/BRIEF.md
# Light-Driver Register Bank and Power-State Controller

This block holds the three control registers of a four-channel LED current-sink driver, as written by a single-wire serial receiver. It turns their contents into the power state of the device and into the enables for the charge pump and oscillator, the four sink channels and two linear regulators. Each regulator also receives a decoded voltage selection. A low-bias flag is raised when the backlight level is small enough to run the sinks on reduced bias current.

The receiver delivers one-cycle write strobes with a 5-bit address and an 8-bit data byte. It also drives a shutdown level, and while that level is high every register is held at zero. Two further inputs come from the analog part: an over-temperature indication and one open-circuit indication per channel.

The controller registers its power state. It sits in sleep whenever no channel is effectively enabled, and in that state the regulators keep their own settings while the pump stays off. An over-temperature condition blanks every output and leaves the registers untouched. A channel that reports an open circuit is latched off.

Top module: `lmu_ctrl`

## Requirements
- R1: While `shdn_i` is high, every register is cleared at the next clock edge and the power state becomes OFF (code 0). In that state the pump, the sinks, both regulators and the low-bias flag are off, and `sink_level_o` reads 0.
- R2: Only the defined fields of each register are stored; reserved bits are ignored. Address 0 holds the level code in data bits 4:0, which `sink_level_o` shows. Address 1 holds the channel enables in bits 3:0, with bit 0 enabling channel 1 (`sink_on_o[0]`) and bit 3 enabling channel 4. Address 3 holds the regulator-1 code in bits 3:0 and the regulator-2 code in bits 6:4.
- R3: A write to any address other than 0, 1 or 3 changes no register and no output.
- R4: Power state codes are OFF=0, SLEEP=1, ACTIVE=2 and HOT=3. The state is updated one clock after its inputs change. When at least one channel is effectively enabled and no over-temperature is present, the state is ACTIVE, `pump_on_o` is 1 and `sink_on_o` equals the effective enables.
- R5: When no channel is effectively enabled, the state is SLEEP. The pump and all sinks are then off, and the regulators follow their own codes.
- R6: A regulator-1 code from 1 to 9 turns regulator 1 on with `reg1_dv_o` = 34 − code, in units of 100 mV (3.3 V down to 2.5 V). Codes 0 and 10 to 15 turn it off with `reg1_dv_o` = 0.
- R7: A regulator-2 code from 1 to 4 turns regulator 2 on with `reg2_dv_o` = 19 − code (1.8 V down to 1.5 V). Codes 0 and 5 to 7 turn it off with `reg2_dv_o` = 0.
- R8: While `hot_i` is high, the state is HOT and the pump, the sinks, both regulators and the low-bias flag are off. Register contents are kept, and the previous outputs return once `hot_i` falls.
- R9: An enabled channel whose `open_i` bit is high at a clock edge, while `hot_i` and `shdn_i` are low, is latched off from that edge on. It stays off until its enable bit is written as 0, or until shutdown. Writing the bit back to 1 after that re-arms the channel.
- R10: `low_bias_o` is 1 exactly when the state is ACTIVE and the level code is 7 or lower (4.0 mA or less).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_i | input | 1 | Shutdown level from the serial receiver; clears the registers |
| wr_i | input | 1 | One-cycle register write strobe |
| wr_addr_i | input | 5 | Register address |
| wr_data_i | input | 8 | Register data |
| hot_i | input | 1 | Over-temperature indication |
| open_i | input | 4 | Per-channel open-circuit indication |
| pstate_o | output | 2 | Power state (0 OFF, 1 SLEEP, 2 ACTIVE, 3 HOT) |
| pump_on_o | output | 1 | Charge pump and oscillator enable |
| sink_on_o | output | 4 | Per-channel current sink enable |
| sink_level_o | output | 5 | Stored backlight level code |
| low_bias_o | output | 1 | Reduced-bias flag for low currents |
| reg1_on_o | output | 1 | Regulator 1 enable |
| reg1_dv_o | output | 6 | Regulator 1 voltage in 100 mV units |
| reg2_on_o | output | 1 | Regulator 2 enable |
| reg2_dv_o | output | 6 | Regulator 2 voltage in 100 mV units |

## Verification
The bench targets the decode edges: regulator-1 codes 9 and 10 and regulator-2 codes 4 and 5. A decoder with an off-by-one range would power a regulator on a reserved code, or drop the lowest valid voltage. It also covers level codes 7 and 8, where a wrong comparison would misreport the low-bias flag. The fault latch is exercised by re-enabling a faulted channel with and without first clearing it; a latch that released too early would turn a faulted sink back on and sustain over-voltage. Over-temperature is applied over stored settings, with writes during the condition, to catch a design that clears registers instead of only blanking outputs.

// File: rtl/lmu_ctrl_pkg.sv
package lmu_ctrl_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int LVL_W  = 5;
  localparam int CH_N   = 4;
  localparam int R1_W   = 4;
  localparam int R2_W   = 3;
  localparam int DV_W   = 6;

  localparam logic [ADDR_W-1:0] A_LEVEL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE = 5'd1;
  localparam logic [ADDR_W-1:0] A_REGUL  = 5'd3;

  localparam logic [LVL_W-1:0] LOW_BIAS_MAX = 5'd7;

  typedef enum logic [1:0] {
    PS_OFF    = 2'd0,
    PS_SLEEP  = 2'd1,
    PS_ACTIVE = 2'd2,
    PS_HOT    = 2'd3
  } pstate_e;

  function automatic logic r1_valid(input logic [R1_W-1:0] c);
    return (c >= R1_W'(1)) && (c <= R1_W'(9));
  endfunction

  function automatic logic [DV_W-1:0] r1_volts(input logic [R1_W-1:0] c);
    return r1_valid(c) ? (DV_W'(34) - DV_W'(c)) : '0;
  endfunction

  function automatic logic r2_valid(input logic [R2_W-1:0] c);
    return (c >= R2_W'(1)) && (c <= R2_W'(4));
  endfunction

  function automatic logic [DV_W-1:0] r2_volts(input logic [R2_W-1:0] c);
    return r2_valid(c) ? (DV_W'(19) - DV_W'(c)) : '0;
  endfunction
endpackage

// File: rtl/lmu_regfile.sv
module lmu_regfile
  import lmu_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [LVL_W-1:0]  level_o,
  output logic [CH_N-1:0]   en_o,
  output logic [R1_W-1:0]   r1_code_o,
  output logic [R2_W-1:0]   r2_code_o
);
  logic hit_level, hit_enable, hit_regul;
  logic unused_bits;

  assign hit_level  = wr_i && (addr_i == A_LEVEL);
  assign hit_enable = wr_i && (addr_i == A_ENABLE);
  assign hit_regul  = wr_i && (addr_i == A_REGUL);
  assign unused_bits = ^data_i[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_o   <= '0;
      en_o      <= '0;
      r1_code_o <= '0;
      r2_code_o <= '0;
    end else if (clr_i) begin
      level_o   <= '0;
      en_o      <= '0;
      r1_code_o <= '0;
      r2_code_o <= '0;
    end else begin
      if (hit_level)  level_o <= data_i[LVL_W-1:0];
      if (hit_enable) en_o    <= data_i[CH_N-1:0];
      if (hit_regul) begin
        r1_code_o <= data_i[R1_W-1:0];
        r2_code_o <= data_i[R1_W+R2_W-1:R1_W];
      end
    end
  end
endmodule

// File: rtl/lmu_fault_latch.sv
module lmu_fault_latch
  import lmu_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            hot_i,
  input  logic [CH_N-1:0] en_i,
  input  logic [CH_N-1:0] open_i,
  output logic [CH_N-1:0] eff_en_o,
  output logic [CH_N-1:0] latched_o
);
  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    logic trip;
    assign trip = open_i[ch] && !hot_i;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     latched_o[ch] <= 1'b0;
      else if (clr_i) latched_o[ch] <= 1'b0;
      else            latched_o[ch] <= en_i[ch] && (latched_o[ch] || trip);
    end
    assign eff_en_o[ch] = en_i[ch] && !latched_o[ch];
  end
endmodule

// File: rtl/lmu_power_fsm.sv
module lmu_power_fsm
  import lmu_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    shdn_i,
  input  logic    hot_i,
  input  logic    any_en_i,
  output pstate_e state_o
);
  pstate_e state_d;

  always_comb begin
    if (shdn_i)        state_d = PS_OFF;
    else if (hot_i)    state_d = PS_HOT;
    else if (any_en_i) state_d = PS_ACTIVE;
    else               state_d = PS_SLEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= PS_OFF;
    else        state_o <= state_d;
  end
endmodule

// File: rtl/lmu_ctrl.sv
module lmu_ctrl
  import lmu_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              hot_i,
  input  logic [CH_N-1:0]   open_i,
  output logic [1:0]        pstate_o,
  output logic              pump_on_o,
  output logic [CH_N-1:0]   sink_on_o,
  output logic [LVL_W-1:0]  sink_level_o,
  output logic              low_bias_o,
  output logic              reg1_on_o,
  output logic [DV_W-1:0]   reg1_dv_o,
  output logic              reg2_on_o,
  output logic [DV_W-1:0]   reg2_dv_o
);
  logic [CH_N-1:0] en_reg, eff_en, latched;
  logic [R1_W-1:0] r1_code;
  logic [R2_W-1:0] r2_code;
  pstate_e         state;
  logic            is_active, regs_live;

  lmu_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .clr_i(shdn_i),
    .wr_i(wr_i), .addr_i(wr_addr_i), .data_i(wr_data_i),
    .level_o(sink_level_o), .en_o(en_reg),
    .r1_code_o(r1_code), .r2_code_o(r2_code)
  );

  lmu_fault_latch u_fault (
    .clk(clk), .rst_n(rst_n), .clr_i(shdn_i), .hot_i(hot_i),
    .en_i(en_reg), .open_i(open_i),
    .eff_en_o(eff_en), .latched_o(latched)
  );

  lmu_power_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .shdn_i(shdn_i), .hot_i(hot_i),
    .any_en_i(|eff_en), .state_o(state)
  );

  assign is_active  = (state == PS_ACTIVE);
  assign regs_live  = (state == PS_ACTIVE) || (state == PS_SLEEP);

  assign pstate_o   = state;
  assign pump_on_o  = is_active;
  assign sink_on_o  = is_active ? eff_en : '0;
  assign low_bias_o = is_active && (sink_level_o <= LOW_BIAS_MAX);
  assign reg1_on_o  = regs_live && r1_valid(r1_code);
  assign reg1_dv_o  = regs_live ? r1_volts(r1_code) : '0;
  assign reg2_on_o  = regs_live && r2_valid(r2_code);
  assign reg2_dv_o  = regs_live ? r2_volts(r2_code) : '0;
endmodule

// File: rtl/lmu_ctrl_chk.sv
module lmu_ctrl_chk
  import lmu_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              shdn_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              hot_i,
  input logic [CH_N-1:0]   open_i,
  input logic [1:0]        pstate_o,
  input logic              pump_on_o,
  input logic [CH_N-1:0]   sink_on_o,
  input logic [LVL_W-1:0]  sink_level_o,
  input logic              low_bias_o,
  input logic              reg1_on_o,
  input logic [DV_W-1:0]   reg1_dv_o,
  input logic              reg2_on_o,
  input logic [DV_W-1:0]   reg2_dv_o
);
  logic unmapped_wr;
  assign unmapped_wr = wr_i && !shdn_i && (wr_addr_i != A_LEVEL) &&
                       (wr_addr_i != A_ENABLE) && (wr_addr_i != A_REGUL);

  AST_SHDN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_i |=> (pstate_o == 2'd0) && (sink_level_o == '0) && !pump_on_o && !reg1_on_o && !reg2_on_o); // R1
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_wr |=> $stable(sink_level_o)); // R3
  AST_SLEEP_PUMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate_o == 2'd1) |-> (!pump_on_o && (sink_on_o == '0))); // R5
  AST_REG1_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reg1_on_o |-> ((reg1_dv_o >= 6'd25) && (reg1_dv_o <= 6'd33))); // R6
  AST_REG2_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reg2_on_o |-> ((reg2_dv_o >= 6'd15) && (reg2_dv_o <= 6'd18))); // R7
  AST_HOT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate_o == 2'd3) |-> (!pump_on_o && (sink_on_o == '0) && !reg1_on_o && !reg2_on_o && !low_bias_o)); // R8
  AST_FAULT_DROPS: assert property (@(posedge clk) disable iff (!rst_n || shdn_i)
    (|(sink_on_o & open_i)) |=> ((sink_on_o & $past(sink_on_o & open_i)) == '0)); // R9
  AST_LOW_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
    low_bias_o |-> (pump_on_o && (sink_level_o <= 5'd7))); // R10
  AST_SINK_NEEDS_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_on_o != '0) |-> (pump_on_o && (pstate_o == 2'd2))); // R4
endmodule

bind lmu_ctrl lmu_ctrl_chk u_chk (.*);

// File: tb/lmu_ctrl_test.sv
module lmu_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shdn_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [4:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       hot_i = 1'b0;
  logic [3:0] open_i = '0;
  logic [1:0] pstate_o;
  logic       pump_on_o;
  logic [3:0] sink_on_o;
  logic [4:0] sink_level_o;
  logic       low_bias_o;
  logic       reg1_on_o;
  logic [5:0] reg1_dv_o;
  logic       reg2_on_o;
  logic [5:0] reg2_dv_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [4:0] m_lvl;
  logic [3:0] m_en, m_lat;
  logic [3:0] m_r1;
  logic [2:0] m_r2;

  always #5 clk = ~clk;

  lmu_ctrl uut (.*);

  function automatic int dv1(input logic [3:0] c);
    if (c == 0 || c > 9) return 0;
    return 34 - int'(c);
  endfunction

  function automatic int dv2(input logic [2:0] c);
    if (c == 0 || c > 4) return 0;
    return 19 - int'(c);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic [3:0] eff;
    int st;
    bit live, act;
    eff = m_en & ~m_lat;
    st = hot_i ? 3 : ((eff != 0) ? 2 : 1);
    act = (st == 2);
    live = (st == 1) || (st == 2);
    chk("R4", "pstate", int'(pstate_o), st);
    chk(act ? "R4" : "R5", "pump", int'(pump_on_o), int'(act));
    chk("R9", "sink_on", int'(sink_on_o), act ? int'(eff) : 0);
    chk("R2", "level", int'(sink_level_o), int'(m_lvl));
    chk("R10", "low_bias", int'(low_bias_o), int'(act && m_lvl <= 7));
    chk("R6", "reg1_on", int'(reg1_on_o), int'(live && dv1(m_r1) != 0));
    chk("R6", "reg1_dv", int'(reg1_dv_o), live ? dv1(m_r1) : 0);
    chk("R7", "reg2_on", int'(reg2_on_o), int'(live && dv2(m_r2) != 0));
    chk("R7", "reg2_dv", int'(reg2_dv_o), live ? dv2(m_r2) : 0);
  endtask

  // one write (optional) then hold hot/open for a few cycles and compare
  task automatic step(input bit w, input logic [4:0] a, input logic [7:0] d,
                      input bit h, input logic [3:0] o);
    @(negedge clk);
    wr_i = w; wr_addr_i = a; wr_data_i = d; hot_i = h; open_i = o;
    @(negedge clk);
    wr_i = 1'b0;
    if (w) begin
      if (a == 5'd0) m_lvl = d[4:0];
      else if (a == 5'd1) m_en = d[3:0];
      else if (a == 5'd3) begin m_r1 = d[3:0]; m_r2 = d[6:4]; end
    end
    m_lat = m_en & (m_lat | (h ? 4'b0 : o));
    repeat (3) @(negedge clk);
    check_all();
  endtask

  task automatic do_shutdown();
    @(negedge clk);
    shdn_i = 1'b1; hot_i = 1'b0; open_i = '0;
    repeat (2) @(negedge clk);
    chk("R1", "off state", int'(pstate_o), 0);
    chk("R1", "level clear", int'(sink_level_o), 0);
    chk("R1", "outputs off", int'({pump_on_o, sink_on_o, reg1_on_o, reg2_on_o, low_bias_o}), 0);
    shdn_i = 1'b0;
    m_lvl = '0; m_en = '0; m_lat = '0; m_r1 = '0; m_r2 = '0;
    repeat (2) @(negedge clk);
    check_all();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_lvl = '0; m_en = '0; m_lat = '0; m_r1 = '0; m_r2 = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset state", int'(pstate_o), 0);
    chk("R1", "reset outputs", int'({pump_on_o, sink_on_o, reg1_on_o, reg2_on_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all();

    // decode boundaries, R6 / R7
    step(1, 5'd3, 8'h49, 0, 0);
    step(1, 5'd3, 8'h5A, 0, 0);
    step(1, 5'd3, 8'h11, 0, 0);
    step(1, 5'd3, 8'h7F, 0, 0);
    step(1, 5'd3, 8'hB4, 0, 0);   // bit 7 reserved, R2
    // level 7 vs 8 with a channel on, R10
    step(1, 5'd0, 8'hE7, 0, 0);
    step(1, 5'd1, 8'hF1, 0, 0);   // reserved upper bits, R2
    step(1, 5'd0, 8'h08, 0, 0);
    // unmapped writes, R3
    step(1, 5'd2, 8'hFF, 0, 0);
    step(1, 5'd31, 8'h00, 0, 0);
    // thermal retention, R8
    step(1, 5'd1, 8'h0F, 1, 0);
    step(0, 5'd0, 8'h00, 1, 4'hF); // faults ignored while hot
    step(0, 5'd0, 8'h00, 0, 0);
    // fault latch, R9
    step(0, 5'd0, 8'h00, 0, 4'h2);
    step(1, 5'd1, 8'h0F, 0, 0);   // rewrite 1 without clearing: stays off
    step(1, 5'd1, 8'h0D, 0, 0);
    step(1, 5'd1, 8'h0F, 0, 0);   // re-armed
    step(0, 5'd0, 8'h00, 0, 4'hF); // all faulted: sleep, R5
    do_shutdown();

    for (int i = 0; i < 400; i++) begin
      logic [4:0] a;
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick < 3) a = 5'd0;
      else if (pick < 6) a = 5'd1;
      else if (pick < 8) a = 5'd3;
      else a = 5'($urandom);
      step($urandom_range(0, 4) != 0, a, 8'($urandom),
           $urandom_range(0, 9) == 0,
           ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0);
      if ($urandom_range(0, 60) == 0) do_shutdown();
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule